// File: doc/BRIEF.md
# Four-Switch Buck-Boost Gate Timing Generator

This block produces the four gate-drive signals for a non-inverting buck-boost bridge built from two half-bridge legs. Each leg runs from its own triangle (up-down) timebase; the second timebase is re-phased by a sync pulse each time the first reaches zero. From a duty word per leg, each leg drives a complementary high/low pair with a programmable dead band between every change of state. The duty word is held in a shadow register and copied into the active compare only when that leg's counter is at zero, so the pulse is symmetric about the counter peak.

Around the two legs the block provides single-cycle ADC start strobes: input-side samples at the first timebase's zero, output-side samples at the second's. A control tick fires on every third switching period so a control loop can run at one third of the switching rate. A direction input reverses power flow: the duty words trade legs and each leg's A/B outputs trade roles. A refresh request forces short inverted pulses on a leg whose duty pins its switches in one state, so the high-side bootstrap supply stays charged. These pulses repeat for three periods to cover the interval between control updates. An active-high disable input turns all gates off.

Top module: `bbPwmGen`

## Requirements
- R1: Each timebase counts 0,1,...,PERIOD,PERIOD-1,...,1 and repeats, so one switching period is 2*PERIOD clocks. `socIn` is a single-cycle pulse in the cycle the first counter is at zero.
- R2: For a leg with active compare D, 1 <= D < PERIOD, and dead time T, the raw state is on while counter + D > PERIOD. That is 2D-1 clocks per period. The high-side gate is on for 2D-1-T clocks and the low-side gate for 2*PERIOD-2D+1-T clocks. The two gates of a leg are never on together.
- R3: A compare of 0 keeps the high-side gate off and the low-side gate on for the whole period. A compare of PERIOD or more keeps the high-side gate on and the low-side gate off.
- R4: `ctrlTick` pulses in exactly one of every three `socIn` pulses, and only in a cycle where `socIn` is high.
- R5: `socOut` pulses at the second timebase's zero. With the default phase of 0, it coincides with `socIn` in every cycle.
- R6: A duty word is copied into a leg's compare only when that leg's counter is at zero. A change made partway through a period takes effect from the next period.
- R7: With `reverseDir` low, leg 1 takes `buckDuty` and leg 2 takes `boostDuty`, and output A is the high side and B the low side. With `reverseDir` high, leg 1 takes `boostDuty`, leg 2 takes `buckDuty`, and A is the low side and B the high side on both legs.
- R8: A one-cycle `refreshReq` arms three refresh events. Each fires at the next counter peak of the target leg. If that leg's compare is 0 or at least PERIOD, its raw state is inverted for REF_LEN clocks, and the dead time still applies. With compare 0, the high-side gate is therefore on for REF_LEN-T clocks at each of three peaks and not afterwards.
- R9: The refresh target is the leg carrying `buckDuty` unless `buckDuty` >= PERIOD (boost operation), in which case it is the leg carrying `boostDuty`. A leg that is not the target receives no refresh pulses.
- R10: While `gateOff` is high, all four gate outputs are low from the next clock edge onward.
- R11: During reset all four gates, `socIn`, `socOut` and `ctrlTick` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| buckDuty | input | CNT_W | Buck-side duty compare word |
| boostDuty | input | CNT_W | Boost-side duty compare word |
| deadTime | input | DT_W | Dead band in clocks inserted at each leg transition |
| reverseDir | input | 1 | 1 selects reverse power flow (duty and A/B exchange) |
| refreshReq | input | 1 | Pulse to arm three bootstrap refresh events |
| gateOff | input | 1 | Active-high disable of all gates |
| leg1A | output | 1 | Leg 1 output A (high side in forward direction) |
| leg1B | output | 1 | Leg 1 output B (low side in forward direction) |
| leg2A | output | 1 | Leg 2 output A (high side in forward direction) |
| leg2B | output | 1 | Leg 2 output B (low side in forward direction) |
| socIn | output | 1 | Input-side ADC start strobe |
| socOut | output | 1 | Output-side ADC start strobe |
| ctrlTick | output | 1 | Control-update strobe, every third period |

## Verification
The bench builds the block with PERIOD=20, CNT_W=8 and REF_LEN=6, and drives a dead time of 2. This makes a switching period 40 clocks, so a single run can cover many periods of steady duty, three-period refresh bursts and the divide-by-three tick. Because on and off times are counted over whole 40-clock windows, the expected gate counts follow from the R2 formulas regardless of where the window starts. The short period also lets a mid-period duty change be placed at a known counter value, so a shadow-load fault shows up as a wrong pulse width.

// File: rtl/bbPwmPkg.sv
package bbPwmPkg;

  // Strobes passed from the control section to one gate leg.
  typedef struct packed {
    logic zero;     // leg counter is at zero: load shadow compare
    logic refresh;  // fire one bootstrap refresh event at this peak
    logic swap;     // exchange A/B outputs (reverse power flow)
  } legStrobeT;

endpackage

// File: rtl/bbPwmCtrl.sv
module bbPwmCtrl
  import bbPwmPkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int PERIOD      = 100,
  parameter int PHASE2      = 0,
  parameter int REF_PERIODS = 3,
  parameter int CTRL_DIV    = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] buckDuty,
  input  logic             reverseDir,
  input  logic             refreshReq,
  output logic [CNT_W-1:0] cnt [2],
  output legStrobeT        strobes [2],
  output logic             socIn,
  output logic             socOut,
  output logic             ctrlTick
);

  localparam int RW = $clog2(REF_PERIODS + 1);
  localparam int DW = (CTRL_DIV > 1) ? $clog2(CTRL_DIV) : 1;

  logic [CNT_W-1:0] cntQ [2];
  logic             upQ [2];
  logic             zeroQ [2];
  logic             peakQ [2];
  logic             syncPulse;

  assign syncPulse = zeroQ[0];

  // Two triangle timebases; the second is re-phased by the first's zero.
  for (genvar g = 0; g < 2; g++) begin : gTb
    logic [CNT_W-1:0] nxt;
    logic             upN;

    always_comb begin
      if (g == 1 && syncPulse) begin
        nxt = CNT_W'(PHASE2 + 1);
        upN = ((PHASE2 + 1) != PERIOD);
      end else if (upQ[g]) begin
        nxt = cntQ[g] + 1'b1;
        upN = (cntQ[g] != CNT_W'(PERIOD - 1));
      end else begin
        nxt = cntQ[g] - 1'b1;
        upN = (cntQ[g] == CNT_W'(1));
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cntQ[g]  <= '0;
        upQ[g]   <= 1'b1;
        zeroQ[g] <= 1'b0;
        peakQ[g] <= 1'b0;
      end else begin
        cntQ[g]  <= nxt;
        upQ[g]   <= upN;
        zeroQ[g] <= (nxt == '0);
        peakQ[g] <= (nxt == CNT_W'(PERIOD));
      end
    end

    assign cnt[g] = cntQ[g];
  end

  // Direction is taken at the first timebase zero so both legs switch cleanly.
  logic dirQ;
  always_ff @(posedge clk) begin
    if (!rstN)         dirQ <= 1'b0;
    else if (zeroQ[0]) dirQ <= reverseDir;
  end

  // Control tick: one of every CTRL_DIV zeros of the first timebase.
  logic [DW-1:0] divQ;
  always_ff @(posedge clk) begin
    if (!rstN) divQ <= '0;
    else if (zeroQ[0]) divQ <= (divQ == DW'(CTRL_DIV - 1)) ? '0 : divQ + 1'b1;
  end

  assign socIn    = zeroQ[0];
  assign socOut   = zeroQ[1];
  assign ctrlTick = zeroQ[0] && (divQ == DW'(CTRL_DIV - 1));

  // Refresh burst: REF_PERIODS events on the peaks of the target leg.
  logic [RW-1:0] refLeft;
  logic          boostMode;
  logic          targetLeg;
  logic          fire;

  assign boostMode = (buckDuty >= CNT_W'(PERIOD));
  assign targetLeg = boostMode ^ dirQ;
  assign fire      = (refLeft != '0) && peakQ[targetLeg];

  always_ff @(posedge clk) begin
    if (!rstN)           refLeft <= '0;
    else if (refreshReq) refLeft <= RW'(REF_PERIODS);
    else if (fire)       refLeft <= refLeft - 1'b1;
  end

  for (genvar g = 0; g < 2; g++) begin : gStb
    assign strobes[g].zero    = zeroQ[g];
    assign strobes[g].refresh = fire && (targetLeg == g[0]);
    assign strobes[g].swap    = dirQ;
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    cntQ[0] <= CNT_W'(PERIOD)) else $error("counter beyond period"); // R1
  AST_SOC_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    socIn |=> !socIn) else $error("socIn wider than one cycle"); // R1
  AST_TICK_WITH_SOC: assert property (@(posedge clk) disable iff (!rstN)
    ctrlTick |-> socIn) else $error("tick away from zero"); // R4
  AST_ONE_REFRESH: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes[0].refresh && strobes[1].refresh)) else $error("two refresh targets"); // R9

endmodule

// File: rtl/bbPwmLeg.sv
module bbPwmLeg
  import bbPwmPkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int PERIOD  = 100,
  parameter int DT_W    = 8,
  parameter int REF_LEN = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  legStrobeT        strobe,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] dutyIn,
  input  logic [DT_W-1:0]  deadTime,
  input  logic             gateOff,
  output logic             gateA,
  output logic             gateB
);

  localparam int RLW = $clog2(REF_LEN + 1);

  // Shadow load of the compare at counter zero.
  logic [CNT_W-1:0] cmpQ;
  always_ff @(posedge clk) begin
    if (!rstN)            cmpQ <= '0;
    else if (strobe.zero) cmpQ <= dutyIn;
  end

  logic full, empty, baseOn;
  assign full   = (cmpQ >= CNT_W'(PERIOD));
  assign empty  = (cmpQ == '0);
  assign baseOn = full ||
                  (({1'b0, cnt} + {1'b0, cmpQ}) > (CNT_W + 1)'(PERIOD));

  // Refresh window: invert the leg state for REF_LEN clocks.
  logic [RLW-1:0] refCnt;
  always_ff @(posedge clk) begin
    if (!rstN)                                 refCnt <= '0;
    else if (strobe.refresh && (full || empty)) refCnt <= RLW'(REF_LEN);
    else if (refCnt != '0)                     refCnt <= refCnt - 1'b1;
  end

  logic rawOn;
  assign rawOn = baseOn ^ (refCnt != '0);

  // Dead band: on every state change both sides stay off for deadTime clocks.
  logic            rawQ;
  logic [DT_W-1:0] dtCnt;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rawQ  <= 1'b0;
      dtCnt <= '0;
    end else if (rawOn != rawQ) begin
      rawQ  <= rawOn;
      dtCnt <= deadTime;
    end else if (dtCnt != '0) begin
      dtCnt <= dtCnt - 1'b1;
    end
  end

  logic hiOn, loOn;
  assign hiOn = rawQ && (dtCnt == '0);
  assign loOn = !rawQ && (dtCnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN || gateOff) begin
      gateA <= 1'b0;
      gateB <= 1'b0;
    end else begin
      gateA <= strobe.swap ? loOn : hiOn;
      gateB <= strobe.swap ? hiOn : loOn;
    end
  end

  AST_NO_SHOOT_THROUGH: assert property (@(posedge clk) disable iff (!rstN)
    !(gateA && gateB)) else $error("both gates of a leg on"); // R2
  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.zero |=> $stable(cmpQ)) else $error("compare changed off zero"); // R6

endmodule

// File: rtl/bbPwmGen.sv
module bbPwmGen
  import bbPwmPkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int PERIOD      = 100,
  parameter int PHASE2      = 0,
  parameter int DT_W        = 8,
  parameter int REF_LEN     = 12,
  parameter int REF_PERIODS = 3,
  parameter int CTRL_DIV    = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] buckDuty,
  input  logic [CNT_W-1:0] boostDuty,
  input  logic [DT_W-1:0]  deadTime,
  input  logic             reverseDir,
  input  logic             refreshReq,
  input  logic             gateOff,
  output logic             leg1A,
  output logic             leg1B,
  output logic             leg2A,
  output logic             leg2B,
  output logic             socIn,
  output logic             socOut,
  output logic             ctrlTick
);

  logic [CNT_W-1:0] cnt [2];
  legStrobeT        strobes [2];
  logic [CNT_W-1:0] legDuty [2];
  logic             gA [2];
  logic             gB [2];

  assign legDuty[0] = reverseDir ? boostDuty : buckDuty;
  assign legDuty[1] = reverseDir ? buckDuty  : boostDuty;

  bbPwmCtrl #(
    .CNT_W(CNT_W), .PERIOD(PERIOD), .PHASE2(PHASE2),
    .REF_PERIODS(REF_PERIODS), .CTRL_DIV(CTRL_DIV)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .buckDuty(buckDuty), .reverseDir(reverseDir),
    .refreshReq(refreshReq), .cnt(cnt), .strobes(strobes),
    .socIn(socIn), .socOut(socOut), .ctrlTick(ctrlTick)
  );

  for (genvar g = 0; g < 2; g++) begin : gLeg
    bbPwmLeg #(
      .CNT_W(CNT_W), .PERIOD(PERIOD), .DT_W(DT_W), .REF_LEN(REF_LEN)
    ) u_leg (
      .clk(clk), .rstN(rstN), .strobe(strobes[g]), .cnt(cnt[g]),
      .dutyIn(legDuty[g]), .deadTime(deadTime), .gateOff(gateOff),
      .gateA(gA[g]), .gateB(gB[g])
    );
  end

  assign leg1A = gA[0];
  assign leg1B = gB[0];
  assign leg2A = gA[1];
  assign leg2B = gB[1];

  AST_GATE_OFF: assert property (@(posedge clk) disable iff (!rstN)
    gateOff |=> !(leg1A || leg1B || leg2A || leg2B)) else $error("gate on while disabled"); // R10

endmodule

// File: tb/bbPwmGen_tb.sv
module bbPwmGen_tb;

  localparam int CNT_W = 8;
  localparam int P     = 20;
  localparam int DT    = 2;
  localparam int RL    = 6;
  localparam int PER   = 2 * P;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [CNT_W-1:0] buckDuty = '0;
  logic [CNT_W-1:0] boostDuty = '0;
  logic [7:0]       deadTime = 8'(DT);
  logic             reverseDir = 1'b0;
  logic             refreshReq = 1'b0;
  logic             gateOff = 1'b0;
  logic leg1A, leg1B, leg2A, leg2B, socIn, socOut, ctrlTick;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  int c1A, c1B, c2A, c2B, cSoc, cTick, cMis;

  always #10 clk = ~clk;

  bbPwmGen #(.CNT_W(CNT_W), .PERIOD(P), .DT_W(8), .REF_LEN(RL)) u_dut (
    .clk(clk), .rstN(rstN), .buckDuty(buckDuty), .boostDuty(boostDuty),
    .deadTime(deadTime), .reverseDir(reverseDir), .refreshReq(refreshReq),
    .gateOff(gateOff), .leg1A(leg1A), .leg1B(leg1B), .leg2A(leg2A),
    .leg2B(leg2B), .socIn(socIn), .socOut(socOut), .ctrlTick(ctrlTick)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic measure(input int n);
    c1A = 0; c1B = 0; c2A = 0; c2B = 0; cSoc = 0; cTick = 0; cMis = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      c1A += leg1A; c1B += leg1B; c2A += leg2A; c2B += leg2B;
      cSoc += socIn; cTick += ctrlTick;
      if (socIn != socOut || (ctrlTick && !socIn)) cMis++;
    end
  endtask

  task automatic settle();
    repeat (3 * PER) @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk({leg1A, leg1B, leg2A, leg2B, socIn, socOut, ctrlTick} == '0, "R11 outputs low in reset",
        int'({leg1A, leg1B, leg2A, leg2B, socIn, socOut, ctrlTick}), 0);
    rstN = 1'b1;
  endtask

  task automatic t_timebase();
    int n = 0;
    do @(negedge clk); while (!socIn);
    do begin @(negedge clk); n++; end while (!socIn);
    chk(n == PER, "R1 period length", n, PER);
    measure(4 * PER);
    chk(cSoc == 4, "R1 socIn pulses per 4 periods", cSoc, 4);
    chk(cMis == 0, "R5 socOut aligned with socIn", cMis, 0);
  endtask

  task automatic t_tick();
    int socs = 0;
    do @(negedge clk); while (!ctrlTick);
    do begin @(negedge clk); socs += socIn; end while (!ctrlTick);
    chk(socs == 3, "R4 socIn pulses per tick", socs, 3);
    measure(6 * PER);
    chk(cTick == 2, "R4 ticks in six periods", cTick, 2);
    chk(cMis == 0, "R4 tick only with socIn", cMis, 0);
  endtask

  task automatic t_duty();
    buckDuty = 8'd5; boostDuty = 8'd12;
    settle(); measure(PER);
    chk(c1A == 2*5-1-DT, "R2 leg1 high side", c1A, 2*5-1-DT);
    chk(c1B == PER-2*5+1-DT, "R2 leg1 low side", c1B, PER-2*5+1-DT);
    chk(c2A == 2*12-1-DT, "R2 leg2 high side", c2A, 2*12-1-DT);
    chk(c2B == PER-2*12+1-DT, "R2 leg2 low side", c2B, PER-2*12+1-DT);
  endtask

  task automatic t_extremes();
    buckDuty = 8'd0; boostDuty = 8'(P);
    settle(); measure(PER);
    chk(c1A == 0, "R3 duty 0 high side off", c1A, 0);
    chk(c1B == PER, "R3 duty 0 low side on", c1B, PER);
    chk(c2A == PER, "R3 full duty high side on", c2A, PER);
    chk(c2B == 0, "R3 full duty low side off", c2B, 0);
    boostDuty = 8'(P + 7);
    settle(); measure(PER);
    chk(c2A == PER, "R3 over-range duty high side on", c2A, PER);
  endtask

  task automatic t_shadow();
    int run;
    buckDuty = 8'd4; boostDuty = 8'd0;
    settle();
    do @(negedge clk); while (!socIn);
    repeat (10) @(negedge clk);
    buckDuty = 8'd12;
    do @(negedge clk); while (!leg1A);
    run = 0;
    while (leg1A) begin run++; @(negedge clk); end
    chk(run == 2*4-1-DT, "R6 old duty holds for current period", run, 2*4-1-DT);
    do @(negedge clk); while (!leg1A);
    run = 0;
    while (leg1A) begin run++; @(negedge clk); end
    chk(run == 2*12-1-DT, "R6 new duty from next period", run, 2*12-1-DT);
  endtask

  task automatic t_reverse();
    buckDuty = 8'd5; boostDuty = 8'd12; reverseDir = 1'b1;
    settle(); measure(PER);
    chk(c1B == 2*12-1-DT, "R7 leg1 B high side from boost duty", c1B, 2*12-1-DT);
    chk(c1A == PER-2*12+1-DT, "R7 leg1 A low side", c1A, PER-2*12+1-DT);
    chk(c2B == 2*5-1-DT, "R7 leg2 B high side from buck duty", c2B, 2*5-1-DT);
    chk(c2A == PER-2*5+1-DT, "R7 leg2 A low side", c2A, PER-2*5+1-DT);
    reverseDir = 1'b0;
    settle();
  endtask

  task automatic pulseRefresh();
    @(negedge clk); refreshReq = 1'b1;
    @(negedge clk); refreshReq = 1'b0;
  endtask

  task automatic t_refresh();
    // buck mode, forward: buck leg (leg1) refreshed
    buckDuty = 8'd0; boostDuty = 8'd0; reverseDir = 1'b0;
    settle(); pulseRefresh(); measure(4 * PER);
    chk(c1A == 3*(RL-DT), "R8 three refresh pulses on buck leg", c1A, 3*(RL-DT));
    chk(c2A == 0, "R9 non-target leg not refreshed", c2A, 0);
    measure(4 * PER);
    chk(c1A == 0, "R8 refresh stops after three periods", c1A, 0);
    // boost mode, forward: boost leg (leg2) refreshed
    buckDuty = 8'(P); boostDuty = 8'd0;
    settle(); pulseRefresh(); measure(4 * PER);
    chk(c2A == 3*(RL-DT), "R9 boost mode refreshes boost leg", c2A, 3*(RL-DT));
    chk(c1B == 0, "R9 buck leg untouched in boost mode", c1B, 0);
    // buck mode, reverse: buck duty sits on leg2, high side is B
    buckDuty = 8'd0; boostDuty = 8'd0; reverseDir = 1'b1;
    settle(); pulseRefresh(); measure(4 * PER);
    chk(c2B == 3*(RL-DT), "R9 reverse refresh on exchanged leg", c2B, 3*(RL-DT));
    chk(c1B == 0, "R9 reverse non-target leg quiet", c1B, 0);
    reverseDir = 1'b0;
    settle();
  endtask

  task automatic t_gateOff();
    buckDuty = 8'd7; boostDuty = 8'd9;
    settle();
    gateOff = 1'b1;
    @(negedge clk);
    chk({leg1A, leg1B, leg2A, leg2B} == 4'b0, "R10 gates off one clock after disable",
        int'({leg1A, leg1B, leg2A, leg2B}), 0);
    measure(PER);
    chk(c1A + c1B + c2A + c2B == 0, "R10 gates stay off", c1A + c1B + c2A + c2B, 0);
    gateOff = 1'b0;
    settle(); measure(PER);
    chk(c1A == 2*7-1-DT, "R10 operation resumes", c1A, 2*7-1-DT);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_timebase();
    t_tick();
    t_duty();
    t_extremes();
    t_shadow();
    t_reverse();
    t_refresh();
    t_gateOff();
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
  end

endmodule